// File: doc/BRIEF.md
# I2C Multi-Message Transaction Sequencer

This block drives a status-coded I2C byte engine through a complete list of messages with no processor in the loop. Each message descriptor supplies a 7- or 10-bit target address, a direction, a byte count and a buffer. The sequencer selects descriptors through `msgSel`, reads outgoing bytes from and stores incoming bytes to an external byte buffer, and answers every engine flag with a write of data and control. Separate messages are joined by a repeated START, and the transaction ends with a STOP and a result code.

The engine raises `engFlag` for one cycle together with an 8-bit status code. The sequencer picks the next action from that code and from its own progress through the current message. All engine and buffer strobes are registered, so each response appears one cycle after the flag. A host abort request, or a programmable wait timeout, makes the transaction close early at the next safe point. A second timeout reinitialises the engine.

Top module: `i2c_msg_seq`

## Requirements
- R1: On status 0x08 or 0x10 with a 7-bit descriptor (`msgTenBit`=0), the block writes the data byte {addr[6:0], dir} (dir=1 for read) together with a control write that has START=0, STOP=0 and interrupt enable=1.
- R2: With `msgTenBit`=1, status 0x08/0x10 sends 0xF0 | (addr[9:8]<<1) | dir, and the following 0x18 (write) or 0x40 (read) sends addr[7:0] before any data or reception.
- R3: On 0x18 (7-bit), 0xD0 or 0x28 with bytes remaining, the block sends the buffer byte at `bufPos` for the selected message, and `bufPos` advances by one.
- R4: On a write acknowledge with no bytes remaining, the block issues STOP and finishes with result 0 (success) if `msgSel` equals `lastIdx`. Otherwise it issues a control write with START=1 and advances `msgSel` by one.
- R5: On 0x40 (7-bit) or 0xE0, a zero-length read issues STOP and finishes with success. Otherwise the block issues a control write only, with ACK=0 exactly when the length is 1.
- R6: On 0x50 the received byte is stored at the current position, and ACK is cleared once the next byte to arrive is the last one (and stays cleared). On 0x58 the byte is stored, STOP is issued with interrupt enable=0, and the block finishes with success. A read message always closes the transaction.
- R7: Status 0x20, 0x30 or 0x48 issues STOP and finishes with result 1 (no device).
- R8: Any status other than 0x08, 0x10, 0x18, 0x20, 0x28, 0x30, 0x40, 0x48, 0x50, 0x58, 0xD0 or 0xE0 issues STOP, pulses `engInit` and finishes with result 2 (bus error).
- R9: A flag that arrives while the block is idle produces only a STOP control write. `done` stays low and no data or buffer strobe occurs.
- R10: After `abortReq`, a write ends with STOP at the next acknowledge once at least one byte of the message has been sent, and never chains a restart. A read clears ACK. The finish reports result 3 (abandoned).
- R11: If no flag arrives for `toLimit`+1 cycles, the block enters the abort state. A second such expiry issues STOP, pulses `engInit` and finishes with result 3.
- R12: After reset all strobes, `busy` and `result` are 0. Every response is registered one cycle after its flag or `go`. Every finish issues STOP with interrupt enable=0 and START=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a transaction at descriptor 0 (ignored while busy) |
| lastIdx | input | IDX_W | Index of the final descriptor |
| abortReq | input | 1 | Request to close the running transaction early |
| toLimit | input | TO_W | Flag wait timeout in cycles, minus one |
| msgSel | output | IDX_W | Selected descriptor index |
| msgAddr | input | 10 | Target address of selected descriptor |
| msgTenBit | input | 1 | Descriptor uses 10-bit addressing |
| msgRead | input | 1 | Descriptor direction, 1 = read |
| msgLen | input | LEN_W | Descriptor byte count |
| bufPos | output | LEN_W | Byte position for buffer reads |
| bufRdData | input | 8 | Buffer byte at (msgSel, bufPos) |
| bufWe | output | 1 | Store a received byte |
| bufWrPos | output | LEN_W | Position of the stored byte |
| bufWrData | output | 8 | Received byte |
| engFlag | input | 1 | Engine has a new status |
| engStatus | input | 8 | Engine status code |
| engRxData | input | 8 | Byte received by the engine |
| engTxWe | output | 1 | Write engine data register |
| engTxData | output | 8 | Byte for the engine |
| engCtrlWe | output | 1 | Write engine control |
| engCtrlStart | output | 1 | Control: generate START |
| engCtrlStop | output | 1 | Control: generate STOP |
| engCtrlAck | output | 1 | Control: acknowledge received byte |
| engCtrlIntEn | output | 1 | Control: flag interrupt enable |
| engInit | output | 1 | Reinitialise the engine |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle finish pulse |
| result | output | 2 | 0 success, 1 no device, 2 bus error, 3 abandoned |

## Verification
The bound checker checks several rules on every cycle. It checks that finishes always carry STOP with the interrupt disabled and leave the block idle, and that START and STOP never share a control write. It also checks that data and buffer strobes only accompany a control write after a flag, that an idle flag produces a bare STOP, and that engine reinitialisation only comes with a failing result. The bench scenarios cover the decisions that depend on history. These are the address byte encodings across every 7- and 10-bit address, restart chaining across descriptors, the sticky ACK release for every read length, the classification of all 256 status codes, and the point at which an abort or a timeout takes effect.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  localparam logic [7:0] SC_START     = 8'h08;
  localparam logic [7:0] SC_RESTART   = 8'h10;
  localparam logic [7:0] SC_WADDR_ACK = 8'h18;
  localparam logic [7:0] SC_WADDR_NAK = 8'h20;
  localparam logic [7:0] SC_WDAT_ACK  = 8'h28;
  localparam logic [7:0] SC_WDAT_NAK  = 8'h30;
  localparam logic [7:0] SC_RADDR_ACK = 8'h40;
  localparam logic [7:0] SC_RADDR_NAK = 8'h48;
  localparam logic [7:0] SC_RDAT_ACK  = 8'h50;
  localparam logic [7:0] SC_RDAT_NAK  = 8'h58;
  localparam logic [7:0] SC_WADR2_ACK = 8'hD0;
  localparam logic [7:0] SC_RADR2_ACK = 8'hE0;

  typedef enum logic [3:0] {
    A_NONE, A_START, A_RESTART, A_ADDR1, A_ADDR2,
    A_DATA, A_RCV, A_CONT, A_RCV_STOP, A_STOP
  } seqAct_e;

  typedef enum logic [1:0] {
    RES_OK = 2'd0, RES_NODEV = 2'd1, RES_BUSERR = 2'd2, RES_ABANDON = 2'd3
  } seqRes_e;

  typedef struct packed {
    seqAct_e act;
    logic    clrAck;
    logic    engInit;
    logic    finish;
    seqRes_e res;
  } seqCmd_t;

endpackage

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       go,
  input  logic       abortReq,
  input  logic       engFlag,
  input  logic [7:0] engStatus,
  input  logic       tenBit,
  input  logic       remZero,
  input  logic       remOne,
  input  logic       remTwo,
  input  logic       posZero,
  input  logic       isLast,
  input  logic       toHit,
  output seqCmd_t    cmd,
  output logic       waiting
);

  typedef enum logic {ST_IDLE, ST_WAIT} seqSt_e;

  seqSt_e st, stNext;
  logic   aborting, abortNext;

  assign waiting = (st == ST_WAIT);

  always_comb begin
    cmd       = '0;
    cmd.act   = A_NONE;
    cmd.res   = RES_OK;
    stNext    = st;
    abortNext = aborting;
    case (st)
      ST_IDLE: begin
        if (engFlag) begin
          cmd.act = A_STOP;
        end else if (go) begin
          cmd.act   = A_START;
          stNext    = ST_WAIT;
          abortNext = 1'b0;
        end
      end
      default: begin
        if (abortReq) abortNext = 1'b1;
        if (engFlag) begin
          case (engStatus)
            SC_START, SC_RESTART: cmd.act = A_ADDR1;
            SC_WADDR_ACK, SC_WADR2_ACK, SC_WDAT_ACK: begin
              if (engStatus == SC_WADDR_ACK && tenBit) begin
                cmd.act = A_ADDR2;
              end else if (remZero || (aborting && !posZero)) begin
                if (isLast || aborting) begin
                  cmd.act    = A_STOP;
                  cmd.finish = 1'b1;
                  cmd.res    = aborting ? RES_ABANDON : RES_OK;
                  stNext     = ST_IDLE;
                end else begin
                  cmd.act = A_RESTART;
                end
              end else begin
                cmd.act = A_DATA;
              end
            end
            SC_RADDR_ACK, SC_RADR2_ACK: begin
              if (engStatus == SC_RADDR_ACK && tenBit) begin
                cmd.act = A_ADDR2;
              end else if (remZero) begin
                cmd.act    = A_STOP;
                cmd.finish = 1'b1;
                cmd.res    = aborting ? RES_ABANDON : RES_OK;
                stNext     = ST_IDLE;
              end else begin
                cmd.act    = A_CONT;
                cmd.clrAck = remOne || aborting;
              end
            end
            SC_RDAT_ACK: begin
              cmd.act    = A_RCV;
              cmd.clrAck = remTwo || aborting;
            end
            SC_RDAT_NAK: begin
              cmd.act    = A_RCV_STOP;
              cmd.finish = 1'b1;
              cmd.res    = aborting ? RES_ABANDON : RES_OK;
              stNext     = ST_IDLE;
            end
            SC_WADDR_NAK, SC_WDAT_NAK, SC_RADDR_NAK: begin
              cmd.act    = A_STOP;
              cmd.finish = 1'b1;
              cmd.res    = RES_NODEV;
              stNext     = ST_IDLE;
            end
            default: begin
              cmd.act     = A_STOP;
              cmd.engInit = 1'b1;
              cmd.finish  = 1'b1;
              cmd.res     = RES_BUSERR;
              stNext      = ST_IDLE;
            end
          endcase
        end else if (toHit) begin
          if (aborting) begin
            cmd.act     = A_STOP;
            cmd.engInit = 1'b1;
            cmd.finish  = 1'b1;
            cmd.res     = RES_ABANDON;
            stNext      = ST_IDLE;
          end else begin
            abortNext = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      aborting <= 1'b0;
    end else begin
      st       <= stNext;
      aborting <= abortNext;
    end
  end

endmodule

// File: rtl/i2cseq_dp.sv
module i2cseq_dp
  import i2cseq_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int LEN_W = 4,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCmd_t          cmd,
  input  logic             waiting,
  input  logic             engFlag,
  input  logic [IDX_W-1:0] lastIdx,
  input  logic [TO_W-1:0]  toLimit,
  input  logic [9:0]       msgAddr,
  input  logic             msgTenBit,
  input  logic             msgRead,
  input  logic [LEN_W-1:0] msgLen,
  input  logic [7:0]       bufRdData,
  input  logic [7:0]       engRxData,
  output logic [IDX_W-1:0] msgSel,
  output logic [LEN_W-1:0] bufPos,
  output logic             remZero,
  output logic             remOne,
  output logic             remTwo,
  output logic             posZero,
  output logic             isLast,
  output logic             toHit,
  output logic             bufWe,
  output logic [LEN_W-1:0] bufWrPos,
  output logic [7:0]       bufWrData,
  output logic             engTxWe,
  output logic [7:0]       engTxData,
  output logic             engCtrlWe,
  output logic             engCtrlStart,
  output logic             engCtrlStop,
  output logic             engCtrlAck,
  output logic             engCtrlIntEn,
  output logic             engInit,
  output logic             done,
  output logic [1:0]       result
);

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_TWO = LEN_W'(2);

  logic [IDX_W-1:0] lastReg;
  logic [LEN_W-1:0] remain;
  logic [TO_W-1:0]  toCnt;
  logic             ackEn, ackNow;
  logic [7:0]       addrFirst, addrSecond;

  assign remain  = msgLen - bufPos;
  assign remZero = (remain == '0);
  assign remOne  = (remain == LEN_ONE);
  assign remTwo  = (remain == LEN_TWO);
  assign posZero = (bufPos == '0);
  assign isLast  = (msgSel == lastReg);
  assign toHit   = waiting && (toCnt == toLimit);
  assign ackNow  = ackEn && !cmd.clrAck;

  assign addrFirst  = msgTenBit ? {5'b11110, msgAddr[9:8], msgRead}
                                : {msgAddr[6:0], msgRead};
  assign addrSecond = msgAddr[7:0];

  always_ff @(posedge clk) begin
    if (!rstN || !waiting || engFlag || toHit) toCnt <= '0;
    else                                      toCnt <= toCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgSel       <= '0;
      lastReg      <= '0;
      bufPos       <= '0;
      ackEn        <= 1'b1;
      bufWe        <= 1'b0;
      bufWrPos     <= '0;
      bufWrData    <= '0;
      engTxWe      <= 1'b0;
      engTxData    <= '0;
      engCtrlWe    <= 1'b0;
      engCtrlStart <= 1'b0;
      engCtrlStop  <= 1'b0;
      engCtrlAck   <= 1'b0;
      engCtrlIntEn <= 1'b0;
      engInit      <= 1'b0;
      done         <= 1'b0;
      result       <= '0;
    end else begin
      bufWe        <= 1'b0;
      engTxWe      <= 1'b0;
      engCtrlWe    <= 1'b0;
      engCtrlStart <= 1'b0;
      engCtrlStop  <= 1'b0;
      engCtrlAck   <= 1'b0;
      engCtrlIntEn <= 1'b0;
      engInit      <= cmd.engInit;
      done         <= cmd.finish;
      if (cmd.finish) result <= cmd.res;
      if (cmd.act != A_NONE) begin
        engCtrlWe    <= 1'b1;
        engCtrlIntEn <= 1'b1;
        engCtrlAck   <= ackNow;
        ackEn        <= ackNow;
      end
      case (cmd.act)
        A_START: begin
          msgSel       <= '0;
          lastReg      <= lastIdx;
          bufPos       <= '0;
          ackEn        <= 1'b1;
          engCtrlAck   <= 1'b1;
          engCtrlStart <= 1'b1;
        end
        A_RESTART: begin
          msgSel       <= msgSel + 1'b1;
          bufPos       <= '0;
          ackEn        <= 1'b1;
          engCtrlAck   <= 1'b1;
          engCtrlStart <= 1'b1;
        end
        A_ADDR1: begin
          engTxWe   <= 1'b1;
          engTxData <= addrFirst;
        end
        A_ADDR2: begin
          engTxWe   <= 1'b1;
          engTxData <= addrSecond;
        end
        A_DATA: begin
          engTxWe   <= 1'b1;
          engTxData <= bufRdData;
          bufPos    <= bufPos + 1'b1;
        end
        A_RCV, A_RCV_STOP: begin
          bufWe     <= 1'b1;
          bufWrPos  <= bufPos;
          bufWrData <= engRxData;
          bufPos    <= bufPos + 1'b1;
          if (cmd.act == A_RCV_STOP) begin
            engCtrlStop  <= 1'b1;
            engCtrlIntEn <= 1'b0;
          end
        end
        A_STOP: begin
          engCtrlStop  <= 1'b1;
          engCtrlIntEn <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import i2cseq_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int LEN_W = 4,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [IDX_W-1:0] lastIdx,
  input  logic             abortReq,
  input  logic [TO_W-1:0]  toLimit,
  output logic [IDX_W-1:0] msgSel,
  input  logic [9:0]       msgAddr,
  input  logic             msgTenBit,
  input  logic             msgRead,
  input  logic [LEN_W-1:0] msgLen,
  output logic [LEN_W-1:0] bufPos,
  input  logic [7:0]       bufRdData,
  output logic             bufWe,
  output logic [LEN_W-1:0] bufWrPos,
  output logic [7:0]       bufWrData,
  input  logic             engFlag,
  input  logic [7:0]       engStatus,
  input  logic [7:0]       engRxData,
  output logic             engTxWe,
  output logic [7:0]       engTxData,
  output logic             engCtrlWe,
  output logic             engCtrlStart,
  output logic             engCtrlStop,
  output logic             engCtrlAck,
  output logic             engCtrlIntEn,
  output logic             engInit,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result
);

  seqCmd_t cmd;
  logic    remZero, remOne, remTwo, posZero, isLast, toHit;

  i2cseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .go       (go),
    .abortReq (abortReq),
    .engFlag  (engFlag),
    .engStatus(engStatus),
    .tenBit   (msgTenBit),
    .remZero  (remZero),
    .remOne   (remOne),
    .remTwo   (remTwo),
    .posZero  (posZero),
    .isLast   (isLast),
    .toHit    (toHit),
    .cmd      (cmd),
    .waiting  (busy)
  );

  i2cseq_dp #(.IDX_W(IDX_W), .LEN_W(LEN_W), .TO_W(TO_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .waiting     (busy),
    .engFlag     (engFlag),
    .lastIdx     (lastIdx),
    .toLimit     (toLimit),
    .msgAddr     (msgAddr),
    .msgTenBit   (msgTenBit),
    .msgRead     (msgRead),
    .msgLen      (msgLen),
    .bufRdData   (bufRdData),
    .engRxData   (engRxData),
    .msgSel      (msgSel),
    .bufPos      (bufPos),
    .remZero     (remZero),
    .remOne      (remOne),
    .remTwo      (remTwo),
    .posZero     (posZero),
    .isLast      (isLast),
    .toHit       (toHit),
    .bufWe       (bufWe),
    .bufWrPos    (bufWrPos),
    .bufWrData   (bufWrData),
    .engTxWe     (engTxWe),
    .engTxData   (engTxData),
    .engCtrlWe   (engCtrlWe),
    .engCtrlStart(engCtrlStart),
    .engCtrlStop (engCtrlStop),
    .engCtrlAck  (engCtrlAck),
    .engCtrlIntEn(engCtrlIntEn),
    .engInit     (engInit),
    .done        (done),
    .result      (result)
  );

endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic [1:0] result,
  input logic       engFlag,
  input logic       engCtrlWe,
  input logic       engCtrlStart,
  input logic       engCtrlStop,
  input logic       engCtrlIntEn,
  input logic       engTxWe,
  input logic       bufWe,
  input logic       engInit
);

  // R12: a finish always closes the bus with interrupts off and leaves idle
  p_finish_stop_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (engCtrlWe && engCtrlStop && !engCtrlStart && !engCtrlIntEn && !busy));

  // R12: START and STOP never requested together
  p_start_stop_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    engCtrlWe |-> !(engCtrlStart && engCtrlStop));

  // R3: every data byte handed to the engine comes with a control write
  p_tx_with_ctrl_r3: assert property (@(posedge clk) disable iff (!rstN)
    engTxWe |-> (engCtrlWe && !engCtrlStop));

  // R6: a byte is stored only in answer to an engine flag
  p_store_after_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> ($past(engFlag) && engCtrlWe));

  // R9: a flag while idle yields a bare STOP and no finish
  p_idle_flag_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (engFlag && !busy) |=> (engCtrlWe && engCtrlStop && !done && !engTxWe && !bufWe));

  // R8: engine reinitialisation only with a failing finish
  p_init_fail_r8: assert property (@(posedge clk) disable iff (!rstN)
    engInit |-> (done && (result == 2'd2 || result == 2'd3)));

  // R12: result only changes when a finish is reported
  p_result_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

endmodule

bind i2c_msg_seq i2cseq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .done        (done),
  .result      (result),
  .engFlag     (engFlag),
  .engCtrlWe   (engCtrlWe),
  .engCtrlStart(engCtrlStart),
  .engCtrlStop (engCtrlStop),
  .engCtrlIntEn(engCtrlIntEn),
  .engTxWe     (engTxWe),
  .bufWe       (bufWe),
  .engInit     (engInit)
);

// File: tb/i2c_msg_seq_tb.sv
`timescale 1ns/1ps
module i2c_msg_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        go = 1'b0;
  logic [2:0]  lastIdx = '0;
  logic        abortReq = 1'b0;
  logic [15:0] toLimit = 16'hFFFF;
  logic [2:0]  msgSel;
  logic [9:0]  msgAddr;
  logic        msgTenBit, msgRead;
  logic [3:0]  msgLen;
  logic [3:0]  bufPos;
  logic [7:0]  bufRdData;
  logic        bufWe;
  logic [3:0]  bufWrPos;
  logic [7:0]  bufWrData;
  logic        engFlag = 1'b0;
  logic [7:0]  engStatus = '0;
  logic [7:0]  engRxData = '0;
  logic        engTxWe;
  logic [7:0]  engTxData;
  logic        engCtrlWe, engCtrlStart, engCtrlStop, engCtrlAck, engCtrlIntEn;
  logic        engInit, busy, done;
  logic [1:0]  result;

  logic [9:0] mAddr [8];
  logic       mTen  [8];
  logic       mRd   [8];
  logic [3:0] mLen  [8];

  int nChecks = 0;
  int nErrs   = 0;
  bit ended   = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input logic [2:0] m, input logic [3:0] p);
    return {m, 1'b1, p} ^ 8'h3C;
  endfunction

  assign msgAddr   = mAddr[msgSel];
  assign msgTenBit = mTen[msgSel];
  assign msgRead   = mRd[msgSel];
  assign msgLen    = mLen[msgSel];
  assign bufRdData = pat(msgSel, bufPos);

  i2c_msg_seq u_dut (
    .clk(clk), .rstN(rstN), .go(go), .lastIdx(lastIdx), .abortReq(abortReq),
    .toLimit(toLimit), .msgSel(msgSel), .msgAddr(msgAddr), .msgTenBit(msgTenBit),
    .msgRead(msgRead), .msgLen(msgLen), .bufPos(bufPos), .bufRdData(bufRdData),
    .bufWe(bufWe), .bufWrPos(bufWrPos), .bufWrData(bufWrData), .engFlag(engFlag),
    .engStatus(engStatus), .engRxData(engRxData), .engTxWe(engTxWe),
    .engTxData(engTxData), .engCtrlWe(engCtrlWe), .engCtrlStart(engCtrlStart),
    .engCtrlStop(engCtrlStop), .engCtrlAck(engCtrlAck), .engCtrlIntEn(engCtrlIntEn),
    .engInit(engInit), .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setMsg(input int i, input logic [9:0] a, input logic t,
                        input logic r, input logic [3:0] l);
    mAddr[i] = a; mTen[i] = t; mRd[i] = r; mLen[i] = l;
  endtask

  task automatic startTx(input logic [2:0] last);
    @(negedge clk); lastIdx = last; go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic flag(input logic [7:0] s, input logic [7:0] rx);
    @(negedge clk); engFlag = 1'b1; engStatus = s; engRxData = rx;
    @(negedge clk); engFlag = 1'b0;
  endtask

  // a finishing response: {ctrlWe, stop, intEn, start, done, busy, result}
  function automatic logic [31:0] finVec();
    return {24'h0, engCtrlWe, engCtrlStop, engCtrlIntEn, engCtrlStart, done, busy, result};
  endfunction
  function automatic logic [31:0] finExp(input logic [1:0] r);
    return {24'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, r};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      nChecks++; nErrs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) setMsg(i, '0, 1'b0, 1'b0, '0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 reset strobes", {engTxWe, engCtrlWe, bufWe, engInit, done, busy, result}, 0);

    // R1 sweep of all 7-bit addresses and both directions
    for (int a = 0; a < 128; a++) begin
      for (int d = 0; d < 2; d++) begin
        setMsg(0, 10'(a), 1'b0, 1'(d), 4'd0);
        startTx(3'd0);
        chk("R12 start ctrl", {engCtrlWe, engCtrlStart, engCtrlStop, busy}, 4'b1101);
        flag(a[0] ? 8'h10 : 8'h08, 8'h00);
        chk("R1 addr byte", {engTxWe, engCtrlWe, engCtrlStart, engCtrlStop, engCtrlIntEn, engTxData},
            {5'b11001, 7'(a), 1'(d)});
        flag(d ? 8'h40 : 8'h18, 8'h00);
        chk(d ? "R5 zero-length read end" : "R4 empty write end", finVec(), finExp(2'd0));
      end
    end

    // R2 sweep of all 10-bit addresses
    for (int a = 0; a < 1024; a++) begin
      for (int d = 0; d < 2; d++) begin
        logic [9:0] av;
        av = 10'(a);
        setMsg(0, av, 1'b1, 1'(d), 4'd0);
        startTx(3'd0);
        flag(8'h08, 8'h00);
        chk("R2 first byte", {engTxWe, engTxData}, {1'b1, 5'b11110, av[9:8], 1'(d)});
        flag(d ? 8'h40 : 8'h18, 8'h00);
        chk("R2 second byte", {engTxWe, engCtrlStop, engTxData}, {2'b10, av[7:0]});
        flag(d ? 8'hE0 : 8'hD0, 8'h00);
        chk("R2 end after second byte", finVec(), finExp(2'd0));
      end
    end

    // R3/R4 chained writes: 3 bytes 7-bit, 2 bytes 10-bit, 1 byte 7-bit
    setMsg(0, 10'h021, 1'b0, 1'b0, 4'd3);
    setMsg(1, 10'h2A5, 1'b1, 1'b0, 4'd2);
    setMsg(2, 10'h05B, 1'b0, 1'b0, 4'd1);
    startTx(3'd2);
    flag(8'h08, 8'h00);
    flag(8'h18, 8'h00);
    chk("R3 data m0 p0", {engTxWe, engTxData}, {1'b1, pat(3'd0, 4'd0)});
    for (int p = 1; p < 3; p++) begin
      flag(8'h28, 8'h00);
      chk("R3 data m0", {engTxWe, engCtrlAck, engTxData}, {2'b11, pat(3'd0, 4'(p))});
    end
    flag(8'h28, 8'h00);
    chk("R4 restart to m1", {engCtrlWe, engCtrlStart, engCtrlStop, engTxWe, done, 5'(msgSel)},
        {5'b11000, 5'd1});
    flag(8'h10, 8'h00);
    chk("R2 m1 first byte", engTxData, 32'hF4);
    flag(8'h18, 8'h00);
    chk("R2 m1 second byte", engTxData, 32'hA5);
    flag(8'hD0, 8'h00);
    chk("R3 data m1 p0", {engTxWe, engTxData}, {1'b1, pat(3'd1, 4'd0)});
    flag(8'h28, 8'h00);
    chk("R3 data m1 p1", {engTxWe, engTxData}, {1'b1, pat(3'd1, 4'd1)});
    flag(8'h28, 8'h00);
    chk("R4 restart to m2", {engCtrlStart, 3'(msgSel)}, {1'b1, 3'd2});
    flag(8'h10, 8'h00);
    chk("R1 m2 addr", engTxData, {7'h5B, 1'b0});
    flag(8'h18, 8'h00);
    chk("R3 data m2 p0", {engTxWe, engTxData}, {1'b1, pat(3'd2, 4'd0)});
    flag(8'h28, 8'h00);
    chk("R4 final stop", finVec(), finExp(2'd0));

    // R5/R6 sweep of read lengths
    for (int len = 1; len < 16; len++) begin
      setMsg(0, 10'h055, 1'b0, 1'b1, 4'(len));
      startTx(3'd0);
      flag(8'h08, 8'h00);
      flag(8'h40, 8'h00);
      chk("R5 read addr ack", {engCtrlWe, engTxWe, engCtrlStop, engCtrlAck}, {3'b100, len > 1});
      for (int k = 0; k < len - 1; k++) begin
        flag(8'h50, 8'(8'h80 + k));
        chk("R6 store byte", {bufWe, bufWrPos, bufWrData, engCtrlAck},
            {1'b1, 4'(k), 8'(8'h80 + k), (len - k - 1) > 1});
      end
      flag(8'h58, 8'hC7);
      chk("R6 last byte stored", {bufWe, bufWrPos, bufWrData}, {1'b1, 4'(len - 1), 8'hC7});
      chk("R6 final read stop", finVec(), finExp(2'd0));
    end

    // R7 no-device statuses
    setMsg(0, 10'h011, 1'b0, 1'b0, 4'd2);
    startTx(3'd0); flag(8'h08, 0); flag(8'h20, 0);
    chk("R7 addr nack write", finVec(), finExp(2'd1));
    startTx(3'd0); flag(8'h08, 0); flag(8'h18, 0); flag(8'h30, 0);
    chk("R7 data nack", finVec(), finExp(2'd1));
    setMsg(0, 10'h011, 1'b0, 1'b1, 4'd2);
    startTx(3'd0); flag(8'h08, 0); flag(8'h48, 0);
    chk("R7 addr nack read", finVec(), finExp(2'd1));

    // R8 every unexpected status
    setMsg(0, 10'h011, 1'b0, 1'b0, 4'd2);
    for (int s = 0; s < 256; s++) begin
      logic [7:0] sv;
      sv = 8'(s);
      if (!(sv inside {8'h08, 8'h10, 8'h18, 8'h20, 8'h28, 8'h30, 8'h40, 8'h48,
                       8'h50, 8'h58, 8'hD0, 8'hE0})) begin
        startTx(3'd0);
        flag(sv, 8'h00);
        chk("R8 bus error", {engInit, finVec()}, {1'b1, finExp(2'd2)});
      end
    end

    // R9 flag while idle
    flag(8'h08, 8'h00);
    chk("R9 idle flag", {engCtrlWe, engCtrlStop, engTxWe, bufWe, done, busy}, 6'b110000);

    // R10 abort during write after one byte: no restart although not last
    setMsg(0, 10'h033, 1'b0, 1'b0, 4'd3);
    startTx(3'd1); flag(8'h08, 0); flag(8'h18, 0);
    @(negedge clk); abortReq = 1'b1; @(negedge clk); abortReq = 1'b0;
    flag(8'h28, 0);
    chk("R10 write abort stop", finVec(), finExp(2'd3));
    // R10 abort before any byte: first byte still sent
    startTx(3'd1); flag(8'h08, 0);
    @(negedge clk); abortReq = 1'b1; @(negedge clk); abortReq = 1'b0;
    flag(8'h18, 0);
    chk("R10 first byte kept", {engTxWe, engTxData}, {1'b1, pat(3'd0, 4'd0)});
    flag(8'h28, 0);
    chk("R10 stop after first byte", finVec(), finExp(2'd3));
    // R10 abort during read clears ACK
    setMsg(0, 10'h033, 1'b0, 1'b1, 4'd4);
    startTx(3'd0); flag(8'h08, 0);
    @(negedge clk); abortReq = 1'b1; @(negedge clk); abortReq = 1'b0;
    flag(8'h40, 0);
    chk("R10 read ack cleared", {engCtrlWe, engCtrlAck}, 2'b10);
    flag(8'h58, 8'h99);
    chk("R10 read abort finish", finVec(), finExp(2'd3));

    // R11 first timeout only arms abort
    toLimit = 16'd5;
    startTx(3'd0); flag(8'h08, 0);
    repeat (7) @(negedge clk);
    chk("R11 no finish on first timeout", {done, busy}, 2'b01);
    flag(8'h40, 0);
    chk("R11 abort state clears ack", {engCtrlWe, engCtrlAck}, 2'b10);
    flag(8'h58, 8'h11);
    chk("R11 finish abandoned", finVec(), finExp(2'd3));
    // R11 second timeout reinitialises the engine
    startTx(3'd0);
    begin
      int waitCyc = 0;
      logic sawInit = 1'b0;
      while (!done && waitCyc < 40) begin
        @(negedge clk); waitCyc++;
        if (done) sawInit = engInit;
      end
      nChecks++;
      if (waitCyc < 10 || waitCyc > 14) begin
        nErrs++;
        $display("FAIL R11 timeout cycles actual=%0d expected=12", waitCyc);
      end
      chk("R11 timeout engine init", {sawInit, result}, 3'b111);
    end
    toLimit = 16'hFFFF;

    ended = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end

endmodule